// File: doc/BRIEF.md
# Accumulator Processor Core with Split Instruction and Data Stores

A small multicycle processor core. A control state machine initialises the machine after reset, then loops over fetch, decode and a class-specific execute sequence. The datapath is a 16-bit accumulator feeding one input of an ALU. The ALU's other input comes from a data store of 16-bit words, and the ALU reports zero and negative status. Instructions are single bytes read from a separate instruction store. The program counter and the instruction register sit in the controller.

Both stores are internal synchronous arrays with one cycle of read latency. A testbench or loader fills them through a write port. That port is honoured only while the reset input is held low. Once the core is running, software-visible state is observed only through the program counter, accumulator, flag and halted outputs.

Top module: `acc_core`

## Requirements
- R1: While `rst_ni` is low, and after the initialise cycle that follows its release, `pc_o`, `acc_o`, `z_o`, `n_o` and `halted_o` are all 0.
- R2: A write on the loader port lands in the instruction store (`wr_sel_i`=0, low 8 bits of `wr_data_i`) or the data store (`wr_sel_i`=1) only while `rst_ni` is low. While running, the port is ignored.
- R3: An instruction byte holds the opcode in bits [7:5] and a 5-bit address or target in bits [4:0]. The opcodes are 000 load, 001 store, 010 add, 011 sub, 100 and, 101 branch-if-zero, 110 branch-if-negative and 111 halt.
- R3 (timing): load, add, sub and and take 5 cycles: fetch, fetch wait, decode, operand wait and execute. Store and branches take 4 cycles. Each result appears after the last edge of its instruction.
- R4: Load copies the addressed data word into the accumulator. Add, sub and and combine the accumulator with the addressed word, modulo 2^16.
- R5: Store writes the accumulator to the addressed data word and leaves the accumulator and flags unchanged.
- R6: Z (result all zero) and N (result bit 15) are updated by load, add, sub and and. They hold across store, branch and halt.
- R7: A branch whose flag is set loads the program counter with bits [4:0] of the instruction.
- R8: A branch whose flag is clear only increments the program counter.
- R9: The program counter wraps from 31 to 0.
- R10: Halt raises `halted_o` 3 cycles after its fetch begins. From then until reset, `halted_o`, `pc_o`, `acc_o` and the flags stay frozen, and `pc_o` holds the halt's own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; also opens the loader port |
| wr_en_i | input | 1 | Loader write strobe |
| wr_sel_i | input | 1 | Loader target: 0 instruction store, 1 data store |
| wr_addr_i | input | 5 | Loader word address |
| wr_data_i | input | 16 | Loader data; instruction store takes bits [7:0] |
| pc_o | output | 5 | Program counter |
| acc_o | output | 16 | Accumulator |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| halted_o | output | 1 | Core is parked after a halt |

## Verification
The hardest state to reach is one where a flag set several instructions earlier decides a branch. The flag must survive an intervening store, or the branch must follow a wrap of the program counter from 31 to 0.

The test program reaches this with a hop to address 30. A subtract at 31 leaves N set, and the branch-if-negative at address 0 is then taken on its second visit, although it fell through on the first. The program also stores a zero result and then branches on the Z flag that the store left untouched. Loader writes are driven while the program runs, aimed at words the program later reads, so that any leak shows up in the accumulator or the halt address.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ADD   = 3'd2,
    OP_SUB   = 3'd3,
    OP_AND   = 3'd4,
    OP_BRZ   = 3'd5,
    OP_BRN   = 3'd6,
    OP_HALT  = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_PASS
  } alu_op_e;

  typedef enum logic [3:0] {
    ST_INIT,
    ST_FETCH,
    ST_FWAIT,
    ST_DECODE,
    ST_OPWAIT,
    ST_LDEX,
    ST_ALUEX,
    ST_STEX,
    ST_BRTAKE,
    ST_BRSKIP,
    ST_HALTED
  } state_e;
endpackage

// File: rtl/acc_sram.sv
module acc_sram #(
  parameter int W  = 16,
  parameter int AW = 5,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu import acc_pkg::*; #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         z_o,
  output logic         n_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      default: res_o = b_i;
    endcase
    z_o = (res_o == '0);
    n_o = res_o[W-1];
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl import acc_pkg::*; #(
  parameter int AW = 5,
  localparam int IW = OPC_W + AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] instr_i,
  input  logic          z_i,
  input  logic          n_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] field_o,
  output alu_op_e       alu_op_o,
  output logic          acc_we_o,
  output logic          clear_o,
  output logic          store_o,
  output logic          halted_o
);
  state_e        state_q, state_d;
  logic [AW-1:0] pc_q;
  logic [IW-1:0] ir_q;
  opcode_e       opc;

  assign opc     = opcode_e'(ir_q[IW-1 -: OPC_W]);
  assign field_o = ir_q[AW-1:0];
  assign pc_o    = pc_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT:   state_d = ST_FETCH;
      ST_FETCH:  state_d = ST_FWAIT;
      ST_FWAIT:  state_d = ST_DECODE;
      ST_DECODE: begin
        unique case (opc)
          OP_STORE: state_d = ST_STEX;
          OP_BRZ:   state_d = z_i ? ST_BRTAKE : ST_BRSKIP;
          OP_BRN:   state_d = n_i ? ST_BRTAKE : ST_BRSKIP;
          OP_HALT:  state_d = ST_HALTED;
          default:  state_d = ST_OPWAIT;
        endcase
      end
      ST_OPWAIT: state_d = (opc == OP_LOAD) ? ST_LDEX : ST_ALUEX;
      ST_HALTED: state_d = ST_HALTED;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      pc_q    <= '0;
      ir_q    <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_INIT:   begin pc_q <= '0; ir_q <= '0; end
        ST_FWAIT:  ir_q <= instr_i;
        ST_BRTAKE: pc_q <= field_o;
        ST_LDEX, ST_ALUEX, ST_STEX, ST_BRSKIP: pc_q <= pc_q + 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (opc)
      OP_ADD:  alu_op_o = ALU_ADD;
      OP_SUB:  alu_op_o = ALU_SUB;
      OP_AND:  alu_op_o = ALU_AND;
      default: alu_op_o = ALU_PASS;
    endcase
  end

  assign acc_we_o = (state_q == ST_LDEX) || (state_q == ST_ALUEX);
  assign clear_o  = (state_q == ST_INIT);
  assign store_o  = (state_q == ST_STEX);
  assign halted_o = (state_q == ST_HALTED);
endmodule

// File: rtl/acc_core.sv
module acc_core import acc_pkg::*; #(
  parameter int DW = 16,
  parameter int AW = 5,
  localparam int IW = OPC_W + AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] acc_o,
  output logic          z_o,
  output logic          n_o,
  output logic          halted_o
);
  logic [DW-1:0] acc_q, alu_res, dmem_rdata, dmem_wdata;
  logic [IW-1:0] imem_rdata;
  logic [AW-1:0] pc, field, dmem_waddr;
  logic          z_q, n_q, alu_z, alu_n;
  logic          acc_we, clear, store, imem_we, dmem_we, load_win;
  alu_op_e       alu_op;

  // loader port is live only while reset is held
  assign load_win   = !rst_ni && wr_en_i;
  assign imem_we    = load_win && !wr_sel_i;
  assign dmem_we    = (load_win && wr_sel_i) || store;
  assign dmem_waddr = rst_ni ? field : wr_addr_i;
  assign dmem_wdata = rst_ni ? acc_q : wr_data_i;

  acc_sram #(.W(IW), .AW(AW)) u_imem (
    .clk_i   (clk_i),
    .we_i    (imem_we),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i[IW-1:0]),
    .raddr_i (pc),
    .rdata_o (imem_rdata)
  );

  acc_sram #(.W(DW), .AW(AW)) u_dmem (
    .clk_i   (clk_i),
    .we_i    (dmem_we),
    .waddr_i (dmem_waddr),
    .wdata_i (dmem_wdata),
    .raddr_i (field),
    .rdata_o (dmem_rdata)
  );

  acc_ctrl #(.AW(AW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .instr_i  (imem_rdata),
    .z_i      (z_q),
    .n_i      (n_q),
    .pc_o     (pc),
    .field_o  (field),
    .alu_op_o (alu_op),
    .acc_we_o (acc_we),
    .clear_o  (clear),
    .store_o  (store),
    .halted_o (halted_o)
  );

  acc_alu #(.W(DW)) u_alu (
    .a_i   (acc_q),
    .b_i   (dmem_rdata),
    .op_i  (alu_op),
    .res_o (alu_res),
    .z_o   (alu_z),
    .n_o   (alu_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      z_q   <= 1'b0;
      n_q   <= 1'b0;
    end else if (clear) begin
      acc_q <= '0;
      z_q   <= 1'b0;
      n_q   <= 1'b0;
    end else if (acc_we) begin
      acc_q <= alu_res;
      z_q   <= alu_z;
      n_q   <= alu_n;
    end
  end

  assign pc_o  = pc;
  assign acc_o = acc_q;
  assign z_o   = z_q;
  assign n_o   = n_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] pc_o,
  input logic [DW-1:0] acc_o,
  input logic          z_o,
  input logic          n_o,
  input logic          halted_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (pc_o == '0 && acc_o == '0 && !z_o && !n_o && !halted_o));

  // R10
  halted_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  // R10
  halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> ($stable(pc_o) && $stable(acc_o) && $stable(z_o) && $stable(n_o)));

  // R6
  flag_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(acc_o) |-> (z_o == (acc_o == '0) && n_o == acc_o[DW-1]));

  // R3
  pc_pace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pc_o) |=> $stable(pc_o));

  // R3
  acc_pace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(acc_o) |=> $stable(acc_o));
endmodule

bind acc_core acc_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pc_o     (pc_o),
  .acc_o    (acc_o),
  .z_o      (z_o),
  .n_o      (n_o),
  .halted_o (halted_o)
);

// File: tb/acc_core_test.sv
module acc_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic          wr_sel_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [AW-1:0] pc_o;
  logic [DW-1:0] acc_o;
  logic          z_o, n_o, halted_o;

  int checks = 0;
  int fails  = 0;

  logic [7:0]    m_im [DEPTH];
  logic [DW-1:0] m_dm [DEPTH];
  logic [AW-1:0] m_pc;
  logic [DW-1:0] m_acc;
  logic          m_z, m_n, m_halt;

  acc_core #(.DW(DW), .AW(AW)) uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog: run hung, actual=running expected=halted");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic [7:0] enc(input int op, input int a);
    return 8'((op << 5) | (a & 31));
  endfunction

  task automatic check_val(input string req, input string what, input logic [DW-1:0] act,
                           input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    checks++;
    if (pc_o !== m_pc || acc_o !== m_acc || z_o !== m_z || n_o !== m_n || halted_o !== m_halt) begin
      fails++;
      $display("FAIL %s @%0t: actual pc=%0d acc=%h z=%b n=%b h=%b expected pc=%0d acc=%h z=%b n=%b h=%b",
               req, $time, pc_o, acc_o, z_o, n_o, halted_o, m_pc, m_acc, m_z, m_n, m_halt);
    end
  endtask

  task automatic tick(input string req);
    @(posedge clk_i);
    #1;
    compare_all(req);
  endtask

  task automatic model_reset();
    m_pc = '0; m_acc = '0; m_z = 1'b0; m_n = 1'b0; m_halt = 1'b0;
  endtask

  task automatic load_word(input bit sel, input int addr, input logic [DW-1:0] data);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_addr_i = AW'(addr); wr_data_i = data;
    @(posedge clk_i);
    #1;
    if (sel) m_dm[addr] = data;
    else m_im[addr] = data[7:0];
    wr_en_i = 1'b0;
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0, 2, 3, 4: return "R3/R4";
      1:          return "R3/R5";
      5, 6:       return "R3/R7/R8";
      default:    return "R10";
    endcase
  endfunction

  // one instruction of the reference model, compared every clock
  task automatic run_instr();
    int op, a, cost;
    logic [AW-1:0] pc0;
    logic [DW-1:0] acc0, res;
    logic z0, n0, taken;
    string tg;
    pc0 = m_pc; acc0 = m_acc; z0 = m_z; n0 = m_n;
    op = int'(m_im[m_pc][7:5]);
    a  = int'(m_im[m_pc][4:0]);
    tg = tag_of(op);
    taken = 1'b0;
    cost = (op == 7) ? 3 : (op == 1 || op == 5 || op == 6) ? 4 : 5;
    for (int k = 1; k < cost; k++) tick(tg);
    @(posedge clk_i);
    res = m_acc;
    case (op)
      0: res = m_dm[a];
      2: res = m_acc + m_dm[a];
      3: res = m_acc - m_dm[a];
      4: res = m_acc & m_dm[a];
      default: ;
    endcase
    case (op)
      0, 2, 3, 4: begin
        m_acc = res; m_z = (res == '0); m_n = res[DW-1]; m_pc = m_pc + 1'b1;
      end
      1: begin m_dm[a] = m_acc; m_pc = m_pc + 1'b1; end
      5, 6: begin
        taken = (op == 5) ? m_z : m_n;
        m_pc = taken ? AW'(a) : AW'(m_pc + 1'b1);
      end
      default: m_halt = 1'b1;
    endcase
    #1;
    compare_all(tg);
    if (op == 1) begin
      check_val("R5", "acc after store", acc_o, acc0);
      check_val("R6", "flags after store", {14'd0, z_o, n_o}, {14'd0, z0, n0});
    end
    if ((op == 5 || op == 6) && taken) check_val("R7", "taken target", DW'(pc_o), DW'(a));
    if ((op == 5 || op == 6) && !taken) check_val("R8", "fallthrough pc", DW'(pc_o), DW'(pc0 + 1'b1));
    if (op != 5 && op != 6 && op != 7 && pc0 == 5'd31) check_val("R9", "pc wrap", DW'(pc_o), '0);
    if (op == 7) check_val("R10", "halted raised", DW'(halted_o), 16'd1);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_im[i] = enc(7, 0); m_dm[i] = '0; end
    model_reset();
    rst_ni = 1'b0;
    #(CLK_PERIOD/4);
    // program 1
    load_word(0, 0,  {8'd0, enc(6, 12)});
    load_word(0, 1,  {8'd0, enc(0, 0)});
    load_word(0, 2,  {8'd0, enc(2, 1)});
    load_word(0, 3,  {8'd0, enc(3, 2)});
    load_word(0, 4,  {8'd0, enc(3, 1)});
    load_word(0, 5,  {8'd0, enc(1, 10)});
    load_word(0, 6,  {8'd0, enc(5, 9)});
    load_word(0, 7,  {8'd0, enc(7, 0)});
    load_word(0, 8,  {8'd0, enc(7, 0)});
    load_word(0, 9,  {8'd0, enc(0, 3)});
    load_word(0, 10, {8'd0, enc(5, 7)});
    load_word(0, 11, {8'd0, enc(6, 30)});
    load_word(0, 30, {8'd0, enc(4, 4)});
    load_word(0, 31, {8'd0, enc(3, 1)});
    load_word(0, 12, {8'd0, enc(0, 10)});
    load_word(0, 13, {8'd0, enc(2, 6)});
    load_word(0, 14, {8'd0, enc(2, 7)});
    load_word(0, 15, {8'd0, enc(1, 11)});
    load_word(0, 16, {8'd0, enc(0, 11)});
    load_word(0, 17, {8'd0, enc(4, 8)});
    load_word(0, 18, {8'd0, enc(7, 0)});
    load_word(1, 0, 16'd5);
    load_word(1, 1, 16'd3);
    load_word(1, 2, 16'd5);
    load_word(1, 3, 16'h8000);
    load_word(1, 4, 16'h00F0);
    load_word(1, 6, 16'h7FFF);
    load_word(1, 7, 16'h0001);
    load_word(1, 8, 16'hFFFF);
    load_word(1, 10, 16'hAAAA);
    check_val("R1", "pc in reset", DW'(pc_o), '0);
    check_val("R1", "acc in reset", acc_o, '0);
    check_val("R1", "status in reset", {13'd0, z_o, n_o, halted_o}, '0);

    // release away from the edge; loader writes now must be ignored (R2)
    @(negedge clk_i);
    rst_ni = 1'b1;
    wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_addr_i = 5'd6; wr_data_i = 16'h1234;
    tick("R1");
    run_instr();
    wr_sel_i = 1'b0; wr_addr_i = 5'd18; wr_data_i = {8'd0, enc(0, 0)};
    run_instr();
    run_instr();
    wr_en_i = 1'b0;
    while (!m_halt) begin
      logic [AW-1:0] p;
      p = m_pc;
      run_instr();
      if (p == 5'd13) check_val("R2", "acc after run-time write attempt", acc_o, 16'h7FFF);
    end
    check_val("R4", "final acc", acc_o, 16'h8000);
    check_val("R6", "final N", DW'(n_o), 16'd1);
    check_val("R10", "halt address", DW'(pc_o), 16'd18);
    for (int i = 0; i < 6; i++) tick("R10");

    // second run: reset from halted, new short program
    @(negedge clk_i);
    rst_ni = 1'b0;
    model_reset();
    #1;
    check_val("R1", "halted cleared by reset", DW'(halted_o), '0);
    check_val("R1", "acc cleared by reset", acc_o, '0);
    load_word(0, 0, {8'd0, enc(0, 2)});
    load_word(0, 1, {8'd0, enc(3, 1)});
    load_word(0, 2, {8'd0, enc(7, 0)});
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick("R1");
    while (!m_halt) run_instr();
    check_val("R4", "second run acc", acc_o, 16'd2);
    check_val("R10", "second halt pc", DW'(pc_o), 16'd2);
    tick("R10");

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule